// File: doc/BRIEF.md
# Error record status register

This block keeps the 64-bit status word of one hardware error record. Detection logic inside the node reports each error as a single event. The event carries a severity class (corrected, deferred or uncorrected) and a corrected-error kind. It also carries an uncorrected-error type, three flags (poison, reported to the requester, critical), a primary and a secondary error code, and two hints saying whether the companion address and miscellaneous registers hold data for this error. The block merges each event into the stored word. The first error fills the record. A later error of equal or higher severity replaces the stored details. A later error of lower severity only adds its sticky class bit and marks overflow.

Software reads the word combinationally and clears it by writing ones over the bits it wants cleared. A clear only takes effect if it covers every one of the nonzero gating fields: record valid, uncorrected, overflow, corrected kind and deferred. This stops software from wiping out an error that arrived between its read and its write. An active-low cold reset zeroes the whole word. A synchronous error-recovery reset freezes it.

The event input uses a valid/ready pair. `ev_ready` is low only while the error-recovery reset is held. An event counts when `ev_valid` and `ev_ready` are both high on a rising clock edge. A producer must hold its event and `ev_valid` until it sees ready. The register port needs no handshake: a write presented with `reg_wr` high is taken or dropped at the next edge.

Top module: `errrec_status`

## Requirements
- R1: After cold reset (`rst_n` low) `reg_rdata` reads all zeros. Bits 63:32 and 18:16 always read zero.
- R2: `ev_class` encodes 01 corrected, 10 deferred, 11 uncorrected, and 00 no error. A class-00 event changes nothing. Any other accepted event sets record valid (bit 30). An uncorrected event sets bit 29 and a deferred event sets bit 23.
- R3: Overflow (bit 27) becomes 1 when an event of any class is accepted while bit 30 is already 1. The first event into an empty record leaves overflow at 0.
- R4: Severity ranks uncorrected above deferred, deferred above corrected, and corrected above an empty record. An event whose rank is at least the stored rank overwrites the primary code, secondary code, poison, type, reported, critical, address-valid and misc-valid fields. A lower-ranked event leaves all of those fields unchanged.
- R5: A corrected event always writes bits 25:24 with its kind: 01 transient, 11 persistent, 10 unclassified. An input kind of 00 is recorded as 10.
- R6: On overwrite, bits 21:20 take `ev_utype` for an uncorrected event and 00 otherwise. Bit 22 takes `ev_poison` for uncorrected or deferred events and 0 for corrected ones. Bits 28, 19, 31 and 26 take the reported, critical, address-valid and misc-valid inputs.
- R7: Bits 15:8 take `ev_sec`. Bits 7:0 take `ev_pri` when it is 0x15 or less; larger values are recorded as 0x01. Bits 7:0 never exceed 0x15.
- R8: In an accepted write, every 1-bit flag with a 1 written is cleared. A 2-bit field (25:24 or 21:20) is cleared only when 11 is written and otherwise keeps its value. Bits 15:0 are not writable.
- R9: A write is dropped in full if any of bits 30, 29, 27, 23 or field 25:24 is nonzero and the write does not put a 1 on every such nonzero bit (11 for field 25:24).
- R10: When an event is accepted in the same cycle as a write, the event is recorded and the write is dropped.
- R11: While `rcv_rst` is high, `ev_ready` is low, events and writes are refused, and the stored word is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| rcv_rst | input | 1 | Error-recovery reset, synchronous, active high, holds state |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Event can be accepted |
| ev_class | input | 2 | Severity class |
| ev_ckind | input | 2 | Corrected-error kind |
| ev_utype | input | 2 | Uncorrected-error type |
| ev_poison | input | 1 | Error came from poisoned data |
| ev_reported | input | 1 | Error was signalled to the requester |
| ev_crit | input | 1 | Critical condition |
| ev_addr_ok | input | 1 | Address register holds data for this error |
| ev_misc_ok | input | 1 | Misc registers hold data for this error |
| ev_pri | input | 8 | Primary error code |
| ev_sec | input | 8 | Secondary, implementation-specific code |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 64 | Write-one-to-clear data |
| reg_rdata | output | 64 | Current status word |

## Verification
The hardest case to reach is a clear that arrives after several errors of different severities have piled up. Only then are overflow, the corrected kind and both sticky class bits nonzero together, so each part of the write gate is actually tested. The bench builds each of the seven non-empty mixes of uncorrected, deferred and corrected events. It follows each mix with every combination of the six gating write bits, and also runs every ordered pair of classes through the priority overwrite. The event/write collision and the recovery-reset freeze are set up by driving both strobes in the same cycle.

// File: rtl/errrec_pkg.sv
package errrec_pkg;
  localparam int CODE_W = 8;
  localparam int REG_W  = 64;

  localparam int P_AV  = 31;
  localparam int P_V   = 30;
  localparam int P_UE  = 29;
  localparam int P_ER  = 28;
  localparam int P_OF  = 27;
  localparam int P_MV  = 26;
  localparam int P_CE  = 24;
  localparam int P_DE  = 23;
  localparam int P_PN  = 22;
  localparam int P_UET = 20;
  localparam int P_CI  = 19;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'b00,
    CLS_CORR   = 2'b01,
    CLS_DEFER  = 2'b10,
    CLS_UNCORR = 2'b11
  } err_cls_e;

  typedef struct packed {
    logic              addr_ok;
    logic              valid;
    logic              uncorr;
    logic              reported;
    logic              ovf;
    logic              misc_ok;
    logic [1:0]        corr;
    logic              defer;
    logic              poison;
    logic [1:0]        utype;
    logic              crit;
    logic [CODE_W-1:0] sec_code;
    logic [CODE_W-1:0] pri_code;
  } rec_t;

  typedef struct packed {
    err_cls_e          cls;
    logic [1:0]        ckind;
    logic [1:0]        utype;
    logic              poison;
    logic              reported;
    logic              crit;
    logic              addr_ok;
    logic              misc_ok;
    logic [CODE_W-1:0] sec;
    logic [CODE_W-1:0] pri;
  } evt_t;

  // clear request bits taken from a software write
  typedef struct packed {
    logic       addr_ok;
    logic       valid;
    logic       uncorr;
    logic       reported;
    logic       ovf;
    logic       misc_ok;
    logic [1:0] corr;
    logic       defer;
    logic       poison;
    logic [1:0] utype;
    logic       crit;
  } clr_t;

  function automatic logic [1:0] rank_of(rec_t r);
    if (r.uncorr)            return 2'd3;
    else if (r.defer)        return 2'd2;
    else if (r.corr != 2'b0) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [REG_W-1:0] pack_rec(rec_t r);
    return {32'h0, r.addr_ok, r.valid, r.uncorr, r.reported, r.ovf, r.misc_ok,
            r.corr, r.defer, r.poison, r.utype, r.crit, 3'b000,
            r.sec_code, r.pri_code};
  endfunction
endpackage

// File: rtl/errrec_merge.sv
module errrec_merge
  import errrec_pkg::*;
#(
  parameter int MAX_PRI   = 21,
  parameter int OTHER_PRI = 1
) (
  input  rec_t cur,
  input  evt_t ev,
  output rec_t nxt,
  output logic overwrite
);
  localparam logic [CODE_W-1:0] MAX_C   = MAX_PRI[CODE_W-1:0];
  localparam logic [CODE_W-1:0] OTHER_C = OTHER_PRI[CODE_W-1:0];

  logic [1:0]        old_rank;
  logic [1:0]        new_rank;
  logic [1:0]        kind_n;
  logic [CODE_W-1:0] pri_n;

  assign old_rank  = rank_of(cur);
  assign new_rank  = ev.cls;
  assign overwrite = (new_rank >= old_rank);
  assign kind_n    = (ev.ckind == 2'b00) ? 2'b10 : ev.ckind;
  assign pri_n     = (ev.pri > MAX_C) ? OTHER_C : ev.pri;

  always_comb begin
    nxt       = cur;
    nxt.valid = 1'b1;
    if (cur.valid) nxt.ovf = 1'b1;
    case (ev.cls)
      CLS_UNCORR: nxt.uncorr = 1'b1;
      CLS_DEFER:  nxt.defer  = 1'b1;
      CLS_CORR:   nxt.corr   = kind_n;
      default:    ;
    endcase
    if (overwrite) begin
      nxt.pri_code = pri_n;
      nxt.sec_code = ev.sec;
      nxt.poison   = (ev.cls != CLS_CORR) && ev.poison;
      nxt.utype    = (ev.cls == CLS_UNCORR) ? ev.utype : 2'b00;
      nxt.reported = ev.reported;
      nxt.crit     = ev.crit;
      nxt.addr_ok  = ev.addr_ok;
      nxt.misc_ok  = ev.misc_ok;
    end
  end
endmodule

// File: rtl/errrec_clear.sv
module errrec_clear
  import errrec_pkg::*;
#(
  parameter int N_GATE = 5
) (
  input  rec_t cur,
  input  clr_t req,
  output logic accept,
  output rec_t nxt
);
  logic [N_GATE-1:0] gate_nz;
  logic [N_GATE-1:0] gate_hit;
  logic [N_GATE-1:0] gate_ok;

  assign gate_nz  = {cur.valid, cur.uncorr, cur.ovf, cur.corr != 2'b00, cur.defer};
  assign gate_hit = {req.valid, req.uncorr, req.ovf, &req.corr, req.defer};

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    assign gate_ok[g] = !gate_nz[g] || gate_hit[g];
  end

  assign accept = &gate_ok;

  always_comb begin
    nxt          = cur;
    nxt.addr_ok  = cur.addr_ok  & ~req.addr_ok;
    nxt.valid    = cur.valid    & ~req.valid;
    nxt.uncorr   = cur.uncorr   & ~req.uncorr;
    nxt.reported = cur.reported & ~req.reported;
    nxt.ovf      = cur.ovf      & ~req.ovf;
    nxt.misc_ok  = cur.misc_ok  & ~req.misc_ok;
    nxt.defer    = cur.defer    & ~req.defer;
    nxt.poison   = cur.poison   & ~req.poison;
    nxt.crit     = cur.crit     & ~req.crit;
    nxt.corr     = (&req.corr)  ? 2'b00 : cur.corr;
    nxt.utype    = (&req.utype) ? 2'b00 : cur.utype;
  end
endmodule

// File: rtl/errrec_status.sv
module errrec_status
  import errrec_pkg::*;
#(
  parameter int MAX_PRI   = 21,
  parameter int OTHER_PRI = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rcv_rst,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_class,
  input  logic [1:0]        ev_ckind,
  input  logic [1:0]        ev_utype,
  input  logic              ev_poison,
  input  logic              ev_reported,
  input  logic              ev_crit,
  input  logic              ev_addr_ok,
  input  logic              ev_misc_ok,
  input  logic [CODE_W-1:0] ev_pri,
  input  logic [CODE_W-1:0] ev_sec,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam logic [CODE_W-1:0] MAX_C = MAX_PRI[CODE_W-1:0];

  rec_t rec_q;
  rec_t ev_next;
  rec_t wr_next;
  evt_t ev_in;
  clr_t clr_in;
  logic ev_fire;
  logic ev_over;
  logic wr_accept;
  logic wr_take;
  logic wdata_unused;

  assign ev_ready = !rcv_rst;
  assign ev_fire  = ev_valid && ev_ready && (ev_class != CLS_NONE);

  assign ev_in = '{cls: err_cls_e'(ev_class), ckind: ev_ckind, utype: ev_utype,
                   poison: ev_poison, reported: ev_reported, crit: ev_crit,
                   addr_ok: ev_addr_ok, misc_ok: ev_misc_ok, sec: ev_sec, pri: ev_pri};

  assign clr_in = '{addr_ok: reg_wdata[P_AV], valid: reg_wdata[P_V],
                    uncorr: reg_wdata[P_UE], reported: reg_wdata[P_ER],
                    ovf: reg_wdata[P_OF], misc_ok: reg_wdata[P_MV],
                    corr: reg_wdata[P_CE+1:P_CE], defer: reg_wdata[P_DE],
                    poison: reg_wdata[P_PN], utype: reg_wdata[P_UET+1:P_UET],
                    crit: reg_wdata[P_CI]};
  assign wdata_unused = ^{reg_wdata[REG_W-1:32], reg_wdata[18:0]};

  errrec_merge #(.MAX_PRI(MAX_PRI), .OTHER_PRI(OTHER_PRI)) u_merge (
    .cur(rec_q), .ev(ev_in), .nxt(ev_next), .overwrite(ev_over)
  );

  errrec_clear #(.N_GATE(5)) u_clear (
    .cur(rec_q), .req(clr_in), .accept(wr_accept), .nxt(wr_next)
  );

  assign wr_take = reg_wr && !rcv_rst && !ev_fire && wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rec_q <= '0;
    else if (ev_fire) rec_q <= ev_next;
    else if (wr_take) rec_q <= wr_next;
  end

  assign reg_rdata = pack_rec(rec_q);

  a_r2_event_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> rec_q.valid);
  a_r3_repeat_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && rec_q.valid) |=> rec_q.ovf);
  a_r4_low_rank_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !ev_over) |=> ($stable(rec_q.pri_code) && $stable(rec_q.sec_code)));
  a_r7_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q.pri_code <= MAX_C);
  a_r9_gated_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ev_fire && !rcv_rst && !wr_accept) |=> $stable(reg_rdata));
  a_r10_event_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ev_fire) |=> rec_q.valid);
  a_r11_recovery_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_rst |=> $stable(rec_q));
endmodule

// File: tb/sim_errrec_status.sv
module sim_errrec_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rcv_rst = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [1:0]  ev_class = '0, ev_ckind = '0, ev_utype = '0;
  logic        ev_poison = 1'b0, ev_reported = 1'b0, ev_crit = 1'b0;
  logic        ev_addr_ok = 1'b0, ev_misc_ok = 1'b0;
  logic [7:0]  ev_pri = '0, ev_sec = '0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  errrec_status u0 (
    .clk(clk), .rst_n(rst_n), .rcv_rst(rcv_rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_class(ev_class), .ev_ckind(ev_ckind), .ev_utype(ev_utype), .ev_poison(ev_poison),
    .ev_reported(ev_reported), .ev_crit(ev_crit), .ev_addr_ok(ev_addr_ok),
    .ev_misc_ok(ev_misc_ok), .ev_pri(ev_pri), .ev_sec(ev_sec), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // expected record, built from the requirements
  logic m_av = 0, m_v = 0, m_ue = 0, m_er = 0, m_of = 0, m_mv = 0, m_de = 0, m_pn = 0, m_ci = 0;
  logic [1:0] m_ce = 0, m_uet = 0;
  logic [7:0] m_sec = 0, m_pri = 0;

  function automatic logic [63:0] m_pack();
    return {32'h0, m_av, m_v, m_ue, m_er, m_of, m_mv, m_ce, m_de, m_pn, m_uet, m_ci,
            3'b000, m_sec, m_pri};
  endfunction

  task automatic m_event(input logic [1:0] c, ck, ut, input logic pn, er, ci, av, mv,
                         input logic [7:0] pri, sec);
    int old_rank;
    old_rank = m_ue ? 3 : m_de ? 2 : (m_ce != 0) ? 1 : 0;
    if (c == 2'b00) return;
    if (m_v) m_of = 1;
    m_v = 1;
    if (c == 2'b11) m_ue = 1;
    if (c == 2'b10) m_de = 1;
    if (c == 2'b01) m_ce = (ck == 2'b00) ? 2'b10 : ck;
    if (int'(c) >= old_rank) begin
      m_pri = (pri > 8'h15) ? 8'h01 : pri;
      m_sec = sec;
      m_pn = (c != 2'b01) && pn;
      m_uet = (c == 2'b11) ? ut : 2'b00;
      m_er = er; m_ci = ci; m_av = av; m_mv = mv;
    end
  endtask

  task automatic m_write(input logic [63:0] w);
    bit acc;
    acc = (!m_v || w[30]) && (!m_ue || w[29]) && (!m_of || w[27]) &&
          (m_ce == 0 || w[25:24] == 2'b11) && (!m_de || w[23]);
    if (!acc) return;
    m_av &= ~w[31]; m_v &= ~w[30]; m_ue &= ~w[29]; m_er &= ~w[28]; m_of &= ~w[27];
    m_mv &= ~w[26]; m_de &= ~w[23]; m_pn &= ~w[22]; m_ci &= ~w[19];
    if (w[25:24] == 2'b11) m_ce = 0;
    if (w[21:20] == 2'b11) m_uet = 0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [1:0] c, ck, ut, input logic pn, er, ci, av, mv,
                          input logic [7:0] pri, sec);
    ev_valid = 1; ev_class = c; ev_ckind = ck; ev_utype = ut; ev_poison = pn;
    ev_reported = er; ev_crit = ci; ev_addr_ok = av; ev_misc_ok = mv; ev_pri = pri; ev_sec = sec;
  endtask

  task automatic do_event(input logic [1:0] c, ck, ut, input logic pn, er, ci, av, mv,
                          input logic [7:0] pri, sec);
    @(negedge clk);
    drive_ev(c, ck, ut, pn, er, ci, av, mv, pri, sec);
    @(negedge clk);
    ev_valid = 0;
    m_event(c, ck, ut, pn, er, ci, av, mv, pri, sec);
  endtask

  task automatic do_write(input logic [63:0] w);
    @(negedge clk);
    reg_wr = 1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 0;
    m_write(w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    chk("R1 reset word", reg_rdata, 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 ready when idle", {63'h0, ev_ready}, 64'h1);

    // R2: no-error class is ignored, first real event sets valid
    do_event(2'b00, 2'b01, 2'b11, 1, 1, 1, 1, 1, 8'h05, 8'h22);
    chk("R2 class 00 ignored", reg_rdata, 64'h0);
    do_event(2'b10, 2'b00, 2'b11, 1, 1, 0, 1, 0, 8'h0C, 8'hA5);
    chk("R2 deferred record", reg_rdata,
        64'h0000_0000_D0C0_0000 | 64'hA50C);
    chk("R3 first event no ovf", {63'h0, reg_rdata[27]}, 64'h0);
    do_event(2'b01, 2'b01, 2'b00, 0, 0, 0, 0, 0, 8'h02, 8'h11);
    chk("R3 repeat sets ovf", {63'h0, reg_rdata[27]}, 64'h1);
    chk("R4 corrected below deferred keeps code", {48'h0, reg_rdata[15:0]}, 64'hA50C);
    chk("R1 reserved bits zero", {32'h0, reg_rdata[63:32]} | {61'h0, reg_rdata[18:16]}, 64'h0);

    // R5: corrected kind encoding
    for (int k = 0; k < 4; k++) begin
      do_write('1);
      do_event(2'b01, 2'(k), 2'b00, 0, 0, 0, 0, 0, 8'h06, 8'h00);
      chk("R5 corrected kind", {62'h0, reg_rdata[25:24]}, (k == 0) ? 64'h2 : 64'(k));
    end

    // R6: corrected event drops poison and type
    do_write('1);
    do_event(2'b01, 2'b11, 2'b11, 1, 1, 1, 1, 1, 8'h03, 8'h44);
    chk("R6 corrected no poison/type", {61'h0, reg_rdata[22:20]}, 64'h0);
    chk("R6 flags copied", {60'h0, reg_rdata[31], reg_rdata[28], reg_rdata[26], reg_rdata[19]}, 64'hF);

    // R7: primary code clamp
    for (int i = 0; i < 4; i++) begin
      logic [7:0] p;
      p = (i == 0) ? 8'h14 : (i == 1) ? 8'h15 : (i == 2) ? 8'h16 : 8'hFF;
      do_write('1);
      do_event(2'b11, 2'b00, 2'b01, 0, 0, 0, 0, 0, p, 8'h7E);
      chk("R7 primary code", {48'h0, reg_rdata[15:0]}, {48'h0, 8'h7E, (p > 8'h15) ? 8'h01 : p});
    end

    // R8: partial type write keeps field, codes not writable
    do_write('1);
    do_event(2'b11, 2'b00, 2'b10, 1, 0, 1, 0, 0, 8'h04, 8'h99);
    do_write(64'h0000_0000_6010_FFFF);
    chk("R8 accepted clear", {62'h0, reg_rdata[30:29]}, 64'h0);
    chk("R8 partial type kept", {62'h0, reg_rdata[21:20]}, 64'h2);
    chk("R8 codes kept", {48'h0, reg_rdata[15:0]}, 64'h9904);
    chk("R8 model", reg_rdata, m_pack());

    // R4: every ordered pair of classes
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_write('1);
        do_event(2'(a), 2'(b), 2'(a), b[0], a[0], b[1], 1'b1, a[1], 8'(a * 5 + b), 8'(8'h40 + a));
        chk("R4 first event", reg_rdata, m_pack());
        do_event(2'(b), 2'(a), 2'(b), a[0], b[0], a[1], a[0], 1'b1, 8'(8'h10 + a * 4 + b), 8'(8'h80 + b));
        chk("R4 second event", reg_rdata, m_pack());
      end
    end

    // R9: each event mix against every gating write pattern
    for (int s = 1; s < 8; s++) begin
      for (int m = 0; m < 64; m++) begin
        do_write('1);
        if (s[0]) do_event(2'b11, 2'b00, 2'b01, 1, 1, 0, 1, 0, 8'h12, 8'h01);
        if (s[1]) do_event(2'b10, 2'b00, 2'b00, 1, 0, 1, 0, 1, 8'h0A, 8'h02);
        if (s[2]) do_event(2'b01, 2'b11, 2'b00, 0, 0, 0, 1, 1, 8'h02, 8'h03);
        w = 64'h0000_0000_9438_0000;
        w[30] = m[0]; w[29] = m[1]; w[27] = m[2]; w[24] = m[3]; w[25] = m[4]; w[23] = m[5];
        do_write(w);
        chk("R9 write gate", reg_rdata, m_pack());
      end
    end

    // R10: event and write in the same cycle
    do_write('1);
    @(negedge clk);
    drive_ev(2'b11, 2'b00, 2'b11, 0, 1, 0, 1, 1, 8'h13, 8'h5A);
    reg_wr = 1; reg_wdata = '1;
    @(negedge clk);
    ev_valid = 0; reg_wr = 0;
    m_event(2'b11, 2'b00, 2'b11, 0, 1, 0, 1, 1, 8'h13, 8'h5A);
    chk("R10 event wins", reg_rdata, m_pack());

    // R11: recovery reset freezes the record
    @(negedge clk);
    rcv_rst = 1;
    #1;
    chk("R11 ready low", {63'h0, ev_ready}, 64'h0);
    drive_ev(2'b01, 2'b01, 2'b00, 0, 0, 0, 0, 0, 8'h01, 8'h01);
    reg_wr = 1; reg_wdata = '1;
    @(negedge clk);
    @(negedge clk);
    ev_valid = 0; reg_wr = 0; rcv_rst = 0;
    @(negedge clk);
    chk("R11 state held", reg_rdata, m_pack());

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule